// File: doc/BRIEF.md
# Start-Time Fair Queuing Rank Calculator

This block assigns a scheduling rank to each arriving packet so that a downstream sorted queue serves flows in an approximately fair order. Each packet arrives with three values: a flow index chosen by upstream classification, a packet length, and the scheduler's current virtual time. The block keeps one finish time per flow. The packet's start time is the later of that flow's finish time and the current virtual time. The start time is returned as the rank, and the flow's finish time then moves forward by the packet length.

Each packet is one read-modify-write of the per-flow table. The table is written one cycle after the packet is accepted, so that the write port stays off the arithmetic path. A bypass forwards the pending write when the next packet belongs to the same flow. Finish-time sums clip at the largest representable time rather than wrapping. Input and output both use valid/ready handshakes. The result sits in an output register: a packet accepted at one edge has its rank valid after that edge.

Top module: `sfq_rank_calc`

## Requirements
- R1: After reset the output is not valid and every flow's finish time is zero. The first packet of any flow therefore receives a rank equal to its virtual time.
- R2: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. A packet is accepted only on an edge where both `in_valid` and `in_ready` are high.
- R3: After the edge that accepts a packet, `out_valid` is high and `out_rank`/`out_flow` show that packet's result. While `out_valid` is high and `out_ready` is low, those outputs hold their values unchanged.
- R4: The rank is the larger of the flow's stored finish time and `in_vtime`.
- R5: After a packet is accepted, the flow's stored finish time equals the rank plus `in_len`.
- R6: A packet accepted on the cycle right after a packet of the same flow sees the finish time that the earlier packet produced.
- R7: If rank plus length exceeds 2^TIME_W−1, the stored finish time becomes 2^TIME_W−1 (all ones) instead of wrapping.
- R8: Updating one flow leaves every other flow's finish time unchanged, including when flows alternate every cycle.
- R9: A packet with length zero receives a normal rank and leaves the flow's finish time equal to that rank.
- R10: Input values presented while no packet is accepted (`in_valid` low, or `in_ready` low during a stall) change no finish time. With `out_ready` high and no acceptance, `out_valid` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet descriptor present |
| in_ready | output | 1 | Block can accept a descriptor this cycle |
| in_flow | input | FLOW_W | Flow index, below FLOWS |
| in_len | input | LEN_W | Packet length in virtual-time units |
| in_vtime | input | TIME_W | Current virtual time |
| out_valid | output | 1 | Rank result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_rank | output | TIME_W | Rank (start time) of the accepted packet |
| out_flow | output | FLOW_W | Flow index of the accepted packet |

## Verification
A corrupted finish-time entry does not show at the ports until the next packet of the same flow. That packet's rank is wrong one cycle after it is accepted, unless its virtual time already exceeds the bad value. For this reason the tests follow every update with a packet of the same flow at a low virtual time. A broken bypass shows only when same-flow packets arrive on consecutive cycles. A missing reset clear shows on the first packet of a flow after reset. A wrapping sum shows as a small rank straight after a packet near the top of the time range.

// File: rtl/sfq_pkg.sv
`timescale 1ns/1ps
package sfq_pkg;
  // Default sizing shared by the block and its checker.
  localparam int unsigned SFQ_FLOWS_DFLT  = 16;
  localparam int unsigned SFQ_TIME_W_DFLT = 24;
  localparam int unsigned SFQ_LEN_W_DFLT  = 16;

  // Where the finish time for a read came from.
  typedef enum logic [1:0] {
    SRC_CLEARED = 2'd0,
    SRC_TABLE   = 2'd1,
    SRC_BYPASS  = 2'd2
  } fin_src_e;
endpackage

// File: rtl/sfq_start_calc.sv
`timescale 1ns/1ps
module sfq_start_calc #(
  parameter int unsigned TIME_W = 24,
  parameter int unsigned LEN_W  = 16
) (
  input  logic [TIME_W-1:0] stored_finish,
  input  logic [TIME_W-1:0] vtime,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic [TIME_W-1:0] start_time,
  output logic [TIME_W-1:0] next_finish
);
  localparam int unsigned PAD_W = TIME_W + 1 - LEN_W;

  logic [TIME_W:0] sum_wide;

  always_comb begin
    start_time = (stored_finish > vtime) ? stored_finish : vtime;
    sum_wide   = {1'b0, start_time} + {{PAD_W{1'b0}}, pkt_len};
    next_finish = sum_wide[TIME_W] ? {TIME_W{1'b1}} : sum_wide[TIME_W-1:0];
  end
endmodule

// File: rtl/sfq_finish_table.sv
`timescale 1ns/1ps
module sfq_finish_table #(
  parameter int unsigned FLOWS  = 16,
  parameter int unsigned TIME_W = 24,
  parameter int unsigned FLOW_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLOW_W-1:0] rd_flow,
  output logic [TIME_W-1:0] rd_finish,
  input  logic              wr_en,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic [TIME_W-1:0] wr_finish
);
  import sfq_pkg::*;

  // Storage without reset so it maps to distributed RAM.
  logic [TIME_W-1:0] mem [FLOWS];
  logic [FLOWS-1:0]  entry_live;

  // Write buffer: the update lands in the array one cycle later.
  logic              wb_vld;
  logic [FLOW_W-1:0] wb_flow;
  logic [TIME_W-1:0] wb_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld  <= 1'b0;
      wb_flow <= '0;
      wb_data <= '0;
    end else begin
      wb_vld  <= wr_en;
      wb_flow <= wr_flow;
      wb_data <= wr_finish;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_vld) mem[wb_flow] <= wb_data;
  end

  // One live flag per entry stands in for clearing the array.
  genvar g;
  generate
    for (g = 0; g < FLOWS; g++) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)
          entry_live[g] <= 1'b0;
        else if (wb_vld && (wb_flow == FLOW_W'(g)))
          entry_live[g] <= 1'b1;
      end
    end
  endgenerate

  fin_src_e src;

  always_comb begin
    if (wb_vld && (wb_flow == rd_flow))
      src = SRC_BYPASS;
    else if (entry_live[rd_flow])
      src = SRC_TABLE;
    else
      src = SRC_CLEARED;

    unique case (src)
      SRC_BYPASS: rd_finish = wb_data;
      SRC_TABLE:  rd_finish = mem[rd_flow];
      default:    rd_finish = '0;
    endcase
  end
endmodule

// File: rtl/sfq_rank_calc.sv
`timescale 1ns/1ps
module sfq_rank_calc #(
  parameter int unsigned FLOWS  = sfq_pkg::SFQ_FLOWS_DFLT,
  parameter int unsigned TIME_W = sfq_pkg::SFQ_TIME_W_DFLT,
  parameter int unsigned LEN_W  = sfq_pkg::SFQ_LEN_W_DFLT,
  localparam int unsigned FLOW_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [TIME_W-1:0] in_vtime,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TIME_W-1:0] out_rank,
  output logic [FLOW_W-1:0] out_flow
);
  logic              accept;
  logic [TIME_W-1:0] cur_finish;
  logic [TIME_W-1:0] start_time;
  logic [TIME_W-1:0] next_finish;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  sfq_finish_table #(
    .FLOWS (FLOWS),
    .TIME_W(TIME_W),
    .FLOW_W(FLOW_W)
  ) table_i (
    .clk      (clk),
    .rst      (rst),
    .rd_flow  (in_flow),
    .rd_finish(cur_finish),
    .wr_en    (accept),
    .wr_flow  (in_flow),
    .wr_finish(next_finish)
  );

  sfq_start_calc #(
    .TIME_W(TIME_W),
    .LEN_W (LEN_W)
  ) calc_i (
    .stored_finish(cur_finish),
    .vtime        (in_vtime),
    .pkt_len      (in_len),
    .start_time   (start_time),
    .next_finish  (next_finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rank  <= '0;
      out_flow  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_rank  <= start_time;
        out_flow  <= in_flow;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfq_rank_calc_chk.sv
`timescale 1ns/1ps
module sfq_rank_calc_chk #(
  parameter int unsigned FLOWS  = 16,
  parameter int unsigned TIME_W = 24,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned FLOW_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [FLOW_W-1:0] in_flow,
  input logic [LEN_W-1:0]  in_len,
  input logic [TIME_W-1:0] in_vtime,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TIME_W-1:0] out_rank,
  input logic [FLOW_W-1:0] out_flow
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1: output idle straight after a reset cycle
  p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  // R2: a held result blocks the input
  p_stall_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: acceptance produces a result with the packet's flow
  p_accept_result_r3: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_valid && out_flow == $past(in_flow)));

  // R3: held result is stable
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rank) && $stable(out_flow)));

  // R4: rank never below the virtual time
  p_rank_floor_r4: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_rank >= $past(in_vtime)));

  // R6: same-flow successor never ranks below its predecessor
  p_same_flow_mono_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && out_valid && in_flow == out_flow) |=> (out_rank >= $past(out_rank)));

  // R10: nothing accepted and result consumed leaves output idle
  p_idle_drains_r10: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !acc) |=> !out_valid);

  logic unused_len;
  assign unused_len = ^in_len;
endmodule

bind sfq_rank_calc sfq_rank_calc_chk #(
  .FLOWS (FLOWS),
  .TIME_W(TIME_W),
  .LEN_W (LEN_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_flow  (in_flow),
  .in_len   (in_len),
  .in_vtime (in_vtime),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_rank (out_rank),
  .out_flow (out_flow)
);

// File: tb/sfq_rank_calc_tb_top.sv
`timescale 1ns/1ps
module sfq_rank_calc_tb_top;
  localparam int unsigned FLOWS  = 16;
  localparam int unsigned TIME_W = 24;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned FLOW_W = 4;
  localparam logic [TIME_W-1:0] TMAX = {TIME_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [FLOW_W-1:0] in_flow = '0;
  logic [LEN_W-1:0]  in_len = '0;
  logic [TIME_W-1:0] in_vtime = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [TIME_W-1:0] out_rank;
  logic [FLOW_W-1:0] out_flow;

  always #2.5 clk = ~clk;

  sfq_rank_calc #(.FLOWS(FLOWS), .TIME_W(TIME_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_flow(in_flow), .in_len(in_len), .in_vtime(in_vtime),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_rank(out_rank), .out_flow(out_flow));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [TIME_W-1:0] exp_fin [FLOWS];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TIME_W-1:0] model_step(int f, int len, logic [TIME_W-1:0] vt);
    logic [TIME_W-1:0] st;
    logic [TIME_W:0] sum;
    st  = (exp_fin[f] > vt) ? exp_fin[f] : vt;
    sum = {1'b0, st} + (TIME_W+1)'(len);
    exp_fin[f] = sum[TIME_W] ? TMAX : sum[TIME_W-1:0];
    return st;
  endfunction

  task automatic push(int f, int len, logic [TIME_W-1:0] vt, string req);
    logic [TIME_W-1:0] er;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_flow = FLOW_W'(f); in_len = LEN_W'(len); in_vtime = vt;
    er = model_step(f, len, vt);
    @(posedge clk); #1;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " rank"},  32'(out_rank),  32'(er));
    chk({req, " flow"},  32'(out_flow),  32'(f));
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < FLOWS; i++) exp_fin[i] = '0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 valid after reset", 32'(out_valid), 32'd0);
    chk("R2 ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_basic();
    push(3, 100, 24'd50, "R1 first packet rank=vtime");
    idle(2);
    push(3, 7, 24'd10, "R5 finish=start+len");
    idle(1);
    push(3, 4, 24'd500, "R4 vtime above finish");
    push(0, 9, 24'd0, "R1 untouched flow 0");
    idle(2);
  endtask

  task automatic t_back_to_back();
    push(5, 10, 24'd0, "R6 b2b first");
    push(5, 20, 24'd0, "R6 b2b second");
    push(5, 30, 24'd0, "R6 b2b third");
    push(5, 1, 24'd0, "R6 b2b fourth");
    idle(2);
  endtask

  task automatic t_interleave();
    push(6, 11, 24'd3, "R8 alt 6");
    push(7, 22, 24'd4, "R8 alt 7");
    push(6, 13, 24'd5, "R8 alt 6");
    push(7, 24, 24'd6, "R8 alt 7");
    push(8, 1, 24'd0, "R8 neighbour untouched");
    idle(2);
  endtask

  task automatic t_stall();
    logic [TIME_W-1:0] er;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    in_flow = 4'd9; in_len = 16'd40; in_vtime = 24'd7;
    er = model_step(9, 40, 24'd7);
    @(posedge clk); #1;
    chk("R3 stalled valid", 32'(out_valid), 32'd1);
    chk("R3 stalled rank", 32'(out_rank), 32'(er));
    chk("R2 ready low in stall", 32'(in_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_flow = 4'd9; in_len = 16'd1000; in_vtime = 24'd0;
      @(posedge clk); #1;
      chk("R3 rank held", 32'(out_rank), 32'(er));
      chk("R3 flow held", 32'(out_flow), 32'd9);
      chk("R2 still blocked", 32'(in_ready), 32'd0);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 drained", 32'(out_valid), 32'd0);
    push(9, 1, 24'd0, "R10 blocked packet left no trace");
    idle(2);
  endtask

  task automatic t_saturate();
    push(12, 500, TMAX - 24'd100, "R7 near top");
    push(12, 5, 24'd0, "R7 saturated finish");
    push(12, 65535, TMAX, "R7 vtime at max");
    idle(1);
  endtask

  task automatic t_zero_len();
    push(1, 0, 24'd20, "R9 zero length rank");
    idle(1);
    push(1, 3, 24'd5, "R9 finish equals rank");
    idle(1);
  endtask

  task automatic t_idle_noise();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    in_flow = 4'd2; in_len = 16'd999; in_vtime = 24'd12345;
    repeat (4) @(posedge clk);
    #1 chk("R10 no output while idle", 32'(out_valid), 32'd0);
    push(2, 1, 24'd0, "R10 idle inputs ignored");
    idle(1);
  endtask

  task automatic t_sweep();
    logic [TIME_W-1:0] vt = 24'd1000;
    for (int i = 0; i < 300; i++) begin
      vt = vt + TIME_W'($urandom % 40);
      push(int'($urandom % FLOWS), int'($urandom % 300), vt, "R4 R5 sweep");
      if (($urandom % 4) == 0) idle(1);
    end
    idle(2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_back_to_back();
    t_interleave();
    t_stall();
    t_saturate();
    t_zero_len();
    t_idle_noise();
    t_sweep();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule